// File: doc/BRIEF.md
# Double-Buffered Converter Input Register

This block is the digital front end of a 12-bit digital-to-analog converter. A 12-bit word is assembled from two parts. An 8-bit low part and a 4-bit high part are each held in a first-rank register of its own. A separate transfer command copies the assembled word into a second-rank output register, and that register drives the converter code. Because of the two ranks, a host on an 8-bit bus can load the two halves in any order without the converter ever seeing a half-updated word. A host on a wide bus can open every rank at once.

All strobes are active low and are sampled on the clock. The master write strobe gates every other enable. A part may be captured and transferred in the same cycle, so the final byte of a sequence costs no extra write. A clear input forces the output register to mid-scale (0x800) at once, without waiting for a clock edge. The clear leaves the first-rank contents untouched. A static mode input selects offset-binary or two's-complement reading of the output code by inverting its top bit.

Top module: `dac_dbuf_front`

## Requirements
- R1: At a clock edge where `wr_n` and `lo_sel_n` are both 0, the low register takes `bus_din[7:0]`. At any other edge it holds its value.
- R2: At a clock edge where `wr_n` and `hi_sel_n` are both 0, the high register takes `bus_din[11:8]`. At any other edge it holds its value.
- R3: At an edge with `wr_n` = 1, no register changes, whatever the three enables are.
- R4: At an edge where `wr_n` and `xfer_n` are both 0, the output register loads {high register, low register}. At any other edge it holds its value, unless a clear or reset is active.
- R5: When a part enable and `xfer_n` are low in the same write cycle, the output register receives the new bus bits for that part. The other part comes from its register.
- R6: With `wr_n`, `lo_sel_n`, `hi_sel_n` and `xfer_n` all 0, the output after the edge equals `bus_din` as it was at that edge.
- R7: While `clr_n` is 0, the output register reads 0x800. This takes effect without a clock edge, and it overrides any transfer.
- R8: `clr_n` does not alter the low or high register. A transfer after the clear is released shows the values captured before or during the clear.
- R9: At an edge with `rst_n` = 0, the output register becomes 0x800 and both part registers become 0.
- R10: `code_out` equals the output register when `twos_mode` = 0. When `twos_mode` = 1, it equals the output register with bit 11 inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous system reset, active low |
| clr_n | input | 1 | Asynchronous mid-scale clear of the output register, active low |
| bus_din | input | 12 | Data bus; bits 7:0 feed the low part, bits 11:8 the high part |
| wr_n | input | 1 | Master write strobe, active low |
| lo_sel_n | input | 1 | Low-part enable, active low |
| hi_sel_n | input | 1 | High-part enable, active low |
| xfer_n | input | 1 | Transfer-to-output enable, active low |
| twos_mode | input | 1 | 1 selects two's-complement reading (top bit inverted) |
| code_out | output | 12 | Converter code |

## Verification
The bench targets the same-cycle capture-and-transfer case. A design that transfers the stale first-rank value would show the old byte for one extra write. It drives enables with `wr_n` high, which catches a design that forgets the master gate and so captures bus noise. It asserts the clear in the middle of a cycle and checks the output before the next edge. A design with a synchronous clear would still show the old code at that point. A design whose clear also wiped the first rank would later transfer zeros instead of the captured parts. Random mixes of strobes and mode flips cover the other orderings.

// File: rtl/dac_dbuf_pkg.sv
// Package: shared types for the double-buffered converter input register.
// Assumes the strobe decode and the register ranks agree on this struct.
package dac_dbuf_pkg;

    // Decoded, active-high capture and transfer qualifiers.
    typedef struct packed {
        logic lo_cap;
        logic hi_cap;
        logic xfer;
    } dbuf_strobe_t;

    // Mid-scale code for a given code width.
    function automatic logic [31:0] mid_scale(input int unsigned width);
        return 32'(1) << (width - 1);
    endfunction

endpackage

// File: rtl/dac_dbuf_decode.sv
// Module: strobe decode. It turns the active-low strobes into active-high
// qualifiers. The master write gates every enable.
// Assumes the strobes are already synchronous to clk.
module dac_dbuf_decode
    import dac_dbuf_pkg::*;
(
    input  logic         wr_n,
    input  logic         lo_sel_n,
    input  logic         hi_sel_n,
    input  logic         xfer_n,
    output dbuf_strobe_t strb
);

    // Qualify each enable with the master write.
    always_comb begin
        strb.lo_cap = ~wr_n & ~lo_sel_n;
        strb.hi_cap = ~wr_n & ~hi_sel_n;
        strb.xfer   = ~wr_n & ~xfer_n;
    end

endmodule

// File: rtl/dac_dbuf_part.sv
// Module: one first-rank part register. It samples its bus slice on a
// qualified edge and otherwise holds. It also offers the value the register
// will hold after this edge, so a transfer in the same cycle sees new data.
// Assumes a synchronous active-low reset to zero.
module dac_dbuf_part #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic [W-1:0] q_next
);

    // Select the incoming slice when capturing, else the held value.
    always_comb q_next = cap ? din : q;

    // Part register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q_next;
    end

    // R1 R2 R3 R8
    property part_hold_p;
        @(posedge clk) disable iff (!rst_n) !cap |=> $stable(q);
    endproperty
    part_hold_chk: assert property (part_hold_p);

    // R1 R2
    property part_take_p;
        @(posedge clk) disable iff (!rst_n) cap |=> (q == $past(din));
    endproperty
    part_take_chk: assert property (part_take_p);

endmodule

// File: rtl/dac_dbuf_outreg.sv
// Module: second-rank output register. It loads the assembled word on a
// transfer. The clear acts asynchronously and forces mid-scale; the system
// reset acts synchronously and also forces mid-scale.
// Assumes clr_n is released away from the active clock edge.
module dac_dbuf_outreg
    import dac_dbuf_pkg::*;
#(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    localparam logic [W-1:0] MID = W'(mid_scale(W));

    // Output rank: async clear, then sync reset, then transfer.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)      q <= MID;
        else if (!rst_n) q <= MID;
        else if (load)   q <= d;
    end

    // R7
    property clr_mid_p;
        @(posedge clk) disable iff (!rst_n) !clr_n |-> (q == MID);
    endproperty
    clr_mid_chk: assert property (clr_mid_p);

    // R4
    property out_hold_p;
        @(posedge clk) disable iff (!rst_n || !clr_n) !load |=> $stable(q);
    endproperty
    out_hold_chk: assert property (out_hold_p);

endmodule

// File: rtl/dac_dbuf_front.sv
// Module: top of the double-buffered converter input register. It joins the
// strobe decode, two first-rank part registers (built in a generate loop)
// and the output register, then applies the static code-reading mode.
// Assumes all inputs except clr_n are synchronous to clk.
module dac_dbuf_front
    import dac_dbuf_pkg::*;
#(
    parameter int unsigned LO_W = 8,
    parameter int unsigned HI_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr_n,
    input  logic [LO_W+HI_W-1:0]   bus_din,
    input  logic                   wr_n,
    input  logic                   lo_sel_n,
    input  logic                   hi_sel_n,
    input  logic                   xfer_n,
    input  logic                   twos_mode,
    output logic [LO_W+HI_W-1:0]   code_out
);

    localparam int unsigned CW = LO_W + HI_W;

    dbuf_strobe_t  strb;
    logic [CW-1:0] rank1_q;
    logic [CW-1:0] rank1_next;
    logic [CW-1:0] out_q;

    dac_dbuf_decode u_decode (
        .wr_n     (wr_n),
        .lo_sel_n (lo_sel_n),
        .hi_sel_n (hi_sel_n),
        .xfer_n   (xfer_n),
        .strb     (strb)
    );

    // One part register per bus slice; slice 0 is the low part.
    for (genvar g = 0; g < 2; g++) begin : g_part
        localparam int unsigned PW  = (g == 0) ? LO_W : HI_W;
        localparam int unsigned LSB = (g == 0) ? 0 : LO_W;
        dac_dbuf_part #(.W(PW)) u_part (
            .clk    (clk),
            .rst_n  (rst_n),
            .cap    ((g == 0) ? strb.lo_cap : strb.hi_cap),
            .din    (bus_din[LSB +: PW]),
            .q      (rank1_q[LSB +: PW]),
            .q_next (rank1_next[LSB +: PW])
        );
    end

    dac_dbuf_outreg #(.W(CW)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_n (clr_n),
        .load  (strb.xfer),
        .d     (rank1_next),
        .q     (out_q)
    );

    // Apply the code-reading mode to the top bit.
    always_comb code_out = {out_q[CW-1] ^ twos_mode, out_q[CW-2:0]};

    // R6
    property all_open_p;
        @(posedge clk) disable iff (!rst_n || !clr_n)
            (!wr_n && !lo_sel_n && !hi_sel_n && !xfer_n) |=> (out_q == $past(bus_din));
    endproperty
    all_open_chk: assert property (all_open_p);

    // R3
    property no_write_p;
        @(posedge clk) disable iff (!rst_n || !clr_n) wr_n |=> $stable(out_q);
    endproperty
    no_write_chk: assert property (no_write_p);

endmodule

// File: tb/dac_dbuf_front_bench.sv
// Bench: seeded random strobes with directed corner cases, checked against a
// model built from the requirements.
module dac_dbuf_front_bench;

    localparam time PERIOD = 20ns;

    logic        clk = 1'b0;
    logic        rst_n, clr_n, wr_n, lo_sel_n, hi_sel_n, xfer_n, twos_mode;
    logic [11:0] bus_din;
    logic [11:0] code_out;

    int checks = 0;
    int fails  = 0;

    logic [7:0]  m_lo;
    logic [3:0]  m_hi;
    logic [11:0] m_out;

    always #(PERIOD/2) clk = ~clk;

    dac_dbuf_front u_dac_dbuf_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_n     (clr_n),
        .bus_din   (bus_din),
        .wr_n      (wr_n),
        .lo_sel_n  (lo_sel_n),
        .hi_sel_n  (hi_sel_n),
        .xfer_n    (xfer_n),
        .twos_mode (twos_mode),
        .code_out  (code_out)
    );

    function automatic logic [11:0] view(input logic [11:0] r, input logic m);
        return m ? {~r[11], r[10:0]} : r;
    endfunction

    task automatic check(input string tag, input logic [11:0] exp);
        checks++;
        if (code_out !== exp) begin
            fails++;
            $display("FAIL %s: code_out=%h expected=%h", tag, code_out, exp);
        end
    endtask

    // Drive one cycle at the falling edge, update the model at the rising
    // edge, and compare a quarter period later.
    task automatic cycle(input logic rs, input logic cl, input logic [11:0] d,
                         input logic w, input logic lo, input logic hi,
                         input logic x, input logic md);
        logic [7:0] lo_n;
        logic [3:0] hi_n;
        string tag;
        @(negedge clk);
        rst_n = rs; clr_n = cl; bus_din = d; wr_n = w;
        lo_sel_n = lo; hi_sel_n = hi; xfer_n = x; twos_mode = md;
        if (!cl) begin
            #1;
            check("R7 async", view(12'h800, md));
        end
        @(posedge clk);
        lo_n = (!w && !lo) ? d[7:0]  : m_lo;
        hi_n = (!w && !hi) ? d[11:8] : m_hi;
        if (!rs) begin
            m_lo = '0; m_hi = '0; m_out = 12'h800;
        end else begin
            if (!cl)            m_out = 12'h800;
            else if (!w && !x)  m_out = {hi_n, lo_n};
            m_lo = lo_n; m_hi = hi_n;
        end
        if (!rs)                         tag = "R9";
        else if (!cl)                    tag = "R7";
        else if (w)                      tag = "R3";
        else if (!lo && !hi && !x)       tag = "R6";
        else if (!x && (!lo || !hi))     tag = "R5";
        else if (!x)                     tag = "R4";
        else if (md)                     tag = "R10";
        else                             tag = "R1 R2";
        #(PERIOD/4);
        check(tag, view(m_out, md));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: expired expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int unsigned seed = 32'd1234;
        void'($urandom(seed));
        rst_n = 0; clr_n = 1; bus_din = '0; wr_n = 1;
        lo_sel_n = 1; hi_sel_n = 1; xfer_n = 1; twos_mode = 0;
        m_lo = '0; m_hi = '0; m_out = 12'h800;

        // R9: reset state
        cycle(0, 1, 12'hABC, 0, 0, 0, 0, 0);
        cycle(0, 1, 12'h000, 1, 1, 1, 1, 0);
        // R3: enables with master write high change nothing
        cycle(1, 1, 12'h5A5, 1, 0, 0, 0, 0);
        // R1, R2 then R4: load parts separately, transfer alone
        cycle(1, 1, 12'h0C3, 0, 0, 1, 1, 0);
        cycle(1, 1, 12'h900, 0, 1, 0, 1, 0);
        cycle(1, 1, 12'hFFF, 0, 1, 1, 0, 0);
        // R5: new low byte captured and transferred in one write
        cycle(1, 1, 12'h07E, 0, 0, 1, 0, 0);
        // R6: all ranks open
        cycle(1, 1, 12'h321, 0, 0, 0, 0, 0);
        // R10: mode flips only the top bit
        cycle(1, 1, 12'h321, 1, 1, 1, 1, 1);
        // R7, R8: clear during a capture and a transfer, then transfer
        cycle(1, 0, 12'hE4D, 0, 0, 0, 0, 0);
        cycle(1, 1, 12'h000, 0, 1, 1, 0, 0);
        check("R8", view(12'hE4D, 0));

        // Random mix.
        for (int i = 0; i < 3000; i++) begin
            logic [11:0] d;
            d = 12'($urandom());
            cycle(($urandom_range(0, 99) != 0),
                  ($urandom_range(0, 19) != 0),
                  d,
                  ($urandom_range(0, 9) < 4),
                  ($urandom_range(0, 1) == 1),
                  ($urandom_range(0, 1) == 1),
                  ($urandom_range(0, 2) != 0),
                  ($urandom_range(0, 7) == 0));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule